// File: doc/BRIEF.md
# Programmable Up-Counting Timer Channel

This block is one timer channel behind a word-wide register port. A 28-bit counter climbs by one on each tick of a programmable prescaler. Software picks a compare value. When the counter reaches that value, or would carry out of its top bit, it returns to zero and a sticky pending flag is raised. The flag drives a level interrupt line through an enable bit.

Two run modes exist. In one-shot mode the channel halts itself after a wrap, so it suits a single delay. In free-running mode it keeps counting from zero, so it suits a periodic tick or a time base. Software stops a running channel by writing zero to the control word. It starts the channel by writing the control word with the enable bit set, normally after loading the counter with zero.

Top module: `tick_wrap_timer`

## Requirements
- R1: After reset, all four registers read as zero and `irq_out` is low.
- R2: Register map, by word offset on `bus_addr`. 0x0 is the compare value in bits [27:0]. 0x4 is the live counter in bits [27:0]; a write loads it directly and takes priority over a tick in the same cycle. 0x8 is the control word: bit 28 enables, bit 24 selects the mode, and bits [15:0] hold the divisor. 0xC is the interrupt word: bit 20 is the enable and bit 16 is the pending flag. Unused bits read as zero.
- R3: While the channel runs, the counter rises by exactly one per tick. A control write with bit 28 at 0 halts the channel, and the counter then holds its value.
- R4: On a tick where the compare value is nonzero and the counter equals it, the counter goes to 0 and the pending flag is set.
- R5: In one-shot mode (bit 24 = 0), counting stops after a wrap, while control bit 28 still reads 1. A new control write with bit 28 set restarts counting.
- R6: In free-running mode (bit 24 = 1), counting continues from 0 after a wrap.
- R7: A divisor D gives one tick every D clocks, and D = 0 acts as 1. Every enabling control write restarts the prescaler, so the first increment lands D clocks after that write.
- R8: A compare value of 0 disables the comparison. A counter at 0x0FFFFFFF then wraps to 0 on the next tick and sets the pending flag.
- R9: `irq_out` is high exactly when both pending and interrupt enable are 1. Writing 1 to bit 16 of the interrupt word clears pending. Writing 0 there leaves it unchanged.
- R10: If a wrap and a clear of pending happen in the same cycle, pending ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Level interrupt |

## Verification
The bench builds the channel with its default widths: a 28-bit counter and a 16-bit divisor. It preloads the counter two steps below the 28-bit limit, so the carry-out wrap comes within a few cycles instead of 2^28 ticks. It uses divisors of 0, 1 and 3 to show the prescaler cadence. Small compare values bring the one-shot halt, the free-running continue, and an exactly aligned wrap-versus-clear collision into view.

// File: rtl/twt_pkg.sv
package twt_pkg;
    localparam int CNT_W  = 28;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CMP  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_INT  = 4'hC;

    localparam int BIT_EN   = 28;
    localparam int BIT_MODE = 24;
    localparam int BIT_IE   = 20;
    localparam int BIT_PEND = 16;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_FREE    = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic             en;
        run_mode_e        mode;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en   = w[BIT_EN];
        c.mode = run_mode_e'(w[BIT_MODE]);
        c.div  = w[DIV_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_EN]    = c.en;
        w[BIT_MODE]  = c.mode;
        w[DIV_W-1:0] = c.div;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] widen(input logic [CNT_W-1:0] v);
        return {{(DATA_W-CNT_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/twt_prescaler.sv
module twt_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] limit;

    assign limit = (div == '0) ? '0 : div - 1'b1;
    assign tick  = active && !restart && (phase == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            phase <= '0;
        end else if (phase == limit) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/twt_counter.sv
module twt_counter #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             free_run,
    input  logic             start,
    input  logic             stop,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             wrap
);
    logic cmp_hit;
    logic top_hit;

    assign cmp_hit = (cmp_val != '0) && (count == cmp_val);
    assign top_hit = &count;
    assign wrap    = tick && running && !load && (cmp_hit || top_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
        end else if (stop) begin
            running <= 1'b0;
        end else if (wrap && !free_run) begin
            running <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (wrap) begin
            count <= '0;
        end else if (tick && running) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/twt_irq.sv
module twt_irq (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wr_ie,
    input  logic wr_clr,
    input  logic set,
    output logic ie,
    output logic pending,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie <= 1'b0;
        end else if (wr) begin
            ie <= wr_ie;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (wr && wr_clr) begin
            pending <= 1'b0;
        end
    end

    assign irq = pending & ie;
endmodule

// File: rtl/tick_wrap_timer.sv
module tick_wrap_timer
    import twt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_wr_val;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             wrap;
    logic             tick;
    logic             ie;
    logic             pending;

    logic wr_cmp, wr_cnt, wr_ctrl, wr_int;
    logic start, stop;

    assign wr_cmp  = bus_wr && (bus_addr == OFS_CMP);
    assign wr_cnt  = bus_wr && (bus_addr == OFS_CNT);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_int  = bus_wr && (bus_addr == OFS_INT);

    assign ctrl_wr_val = ctrl_unpack(bus_wdata);
    assign start       = wr_ctrl && ctrl_wr_val.en;
    assign stop        = wr_ctrl && !ctrl_wr_val.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_wr_val;
            if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
        end
    end

    twt_prescaler #(.DIV_W(DIV_W)) i_psc (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .active  (running),
        .div     (ctrl_q.div),
        .tick    (tick)
    );

    twt_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmp_val  (cmp_q),
        .free_run (ctrl_q.mode == MODE_FREE),
        .start    (start),
        .stop     (stop),
        .load     (wr_cnt),
        .load_val (bus_wdata[CNT_W-1:0]),
        .count    (count),
        .running  (running),
        .wrap     (wrap)
    );

    twt_irq i_irq (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_int),
        .wr_ie   (bus_wdata[BIT_IE]),
        .wr_clr  (bus_wdata[BIT_PEND]),
        .set     (wrap),
        .ie      (ie),
        .pending (pending),
        .irq     (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CMP:  bus_rdata = widen(cmp_q);
            OFS_CNT:  bus_rdata = widen(count);
            OFS_CTRL: bus_rdata = ctrl_pack(ctrl_q);
            OFS_INT: begin
                bus_rdata[BIT_IE]   = ie;
                bus_rdata[BIT_PEND] = pending;
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/twt_checker.sv
module twt_checker #(
    parameter int CNT_W = 28
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wrap,
    input logic             running,
    input logic             free_run,
    input logic             wr_cnt,
    input logic             wr_ctrl,
    input logic [CNT_W-1:0] count,
    input logic             pending,
    input logic             irq_out
);
    // R3: an ordinary tick advances the counter by one
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (tick && running && !wrap && !wr_cnt) |=> (count == $past(count) + 1'b1));

    // R3: a halted channel with no load holds its count
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr_cnt) |=> $stable(count));

    // R4: a wrap without a load lands on zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (wrap && !wr_cnt) |=> (count == '0));

    // R5: one-shot mode halts after a wrap
    a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
        (wrap && !free_run && !wr_ctrl) |=> !running);

    // R10: a wrap always leaves pending set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        wrap |=> pending);

    // R9: the interrupt line never rises without pending
    a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> pending);
endmodule

bind tick_wrap_timer twt_checker #(.CNT_W(twt_pkg::CNT_W)) i_twt_checker (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wrap     (wrap),
    .running  (running),
    .free_run (ctrl_q.mode == twt_pkg::MODE_FREE),
    .wr_cnt   (wr_cnt),
    .wr_ctrl  (wr_ctrl),
    .count    (count),
    .pending  (pending),
    .irq_out  (irq_out)
);

// File: tb/test_tick_wrap_timer.sv
module test_tick_wrap_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;

    localparam logic [3:0] A_CMP = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_INT = 4'hC;
    localparam logic [31:0] EN = 32'h1000_0000, FREE = 32'h0100_0000;
    localparam logic [31:0] IE = 32'h0010_0000, PEND = 32'h0001_0000;

    always #5 clk = ~clk;

    tick_wrap_timer i_tick_wrap_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        wr(A_CTRL, 32'h0);
        wr(A_INT, PEND);
        wr(A_CNT, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CMP, v);  check("R1 cmp", v, 0);
        rd(A_CNT, v);  check("R1 cnt", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_INT, v);  check("R1 int", v, 0);
        check("R1 irq", {31'b0, irq_out}, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(A_CMP, 32'd5);
        rd(A_CMP, v); check("R2 cmp readback", v, 5);
        wr(A_CTRL, EN | 32'd1);
        edges(3);
        rd(A_CNT, v); check("R3 count after 3", v, 3);
        edges(3);
        rd(A_CNT, v); check("R4 wrap to zero", v, 0);
        rd(A_INT, v); check("R4 pending set", v, PEND);
        edges(4);
        rd(A_CNT, v); check("R5 halted", v, 0);
        rd(A_CTRL, v); check("R5 enable still reads 1", v, EN | 32'd1);
        wr(A_CTRL, EN | 32'd1);
        edges(2);
        rd(A_CNT, v); check("R5 restart", v, 2);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(A_CTRL, 32'h0);
        check("R9 irq masked", {31'b0, irq_out}, 0);
        wr(A_INT, IE);
        check("R9 irq asserted", {31'b0, irq_out}, 1);
        rd(A_INT, v); check("R9 int readback", v, IE | PEND);
        wr(A_INT, IE | PEND);
        check("R9 irq cleared", {31'b0, irq_out}, 0);
        rd(A_INT, v); check("R9 pending cleared", v, IE);
    endtask

    task automatic t_free();
        logic [31:0] v;
        quiesce();
        wr(A_CMP, 32'd3);
        wr(A_CTRL, EN | FREE | 32'd1);
        edges(4);
        rd(A_CNT, v); check("R4 free wrap", v, 0);
        rd(A_INT, v); check("R4 free pending", v, PEND);
        edges(2);
        rd(A_CNT, v); check("R6 keeps counting", v, 2);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        quiesce();
        wr(A_CMP, 32'd0);
        wr(A_CTRL, EN | 32'd3);
        edges(2);
        rd(A_CNT, v); check("R7 div3 before first tick", v, 0);
        edges(1);
        rd(A_CNT, v); check("R7 div3 first tick", v, 1);
        edges(4);
        rd(A_CNT, v); check("R7 div3 after 7", v, 2);
        quiesce();
        wr(A_CTRL, EN | 32'd0);
        edges(4);
        rd(A_CNT, v); check("R7 div0 acts as 1", v, 4);
    endtask

    task automatic t_rollover();
        logic [31:0] v;
        quiesce();
        wr(A_CMP, 32'd0);
        wr(A_CNT, 32'h0FFF_FFFD);
        wr(A_CTRL, EN | FREE | 32'd1);
        edges(2);
        rd(A_CNT, v); check("R8 at top", v, 32'h0FFF_FFFF);
        rd(A_INT, v); check("R8 no pending yet", v, 0);
        edges(1);
        rd(A_CNT, v); check("R8 rolled over", v, 0);
        rd(A_INT, v); check("R8 pending", v, PEND);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        quiesce();
        wr(A_CMP, 32'd2);
        wr(A_CTRL, EN | FREE | 32'd1);
        edges(2);
        wr(A_INT, IE | PEND);
        rd(A_INT, v); check("R10 set beats clear", v, IE | PEND);
        check("R10 irq high", {31'b0, irq_out}, 1);
        rd(A_CNT, v); check("R10 count at wrap", v, 0);
        edges(1);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R3 stop value", v, 2);
        edges(5);
        rd(A_CNT, v); check("R3 held after stop", v, 2);
    endtask

    task automatic t_load();
        logic [31:0] v;
        quiesce();
        wr(A_CMP, 32'd0);
        wr(A_CTRL, EN | FREE | 32'd1);
        edges(1);
        wr(A_CNT, 32'd100);
        rd(A_CNT, v); check("R2 load wins over tick", v, 100);
        edges(3);
        rd(A_CNT, v); check("R2 counts from load", v, 103);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_oneshot();
        t_irq();
        t_free();
        t_prescale();
        t_rollover();
        t_collide();
        t_load();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule